// File: doc/BRIEF.md
# Debug Command Decoder and Executor

This block sits between a host-side shift interface and the target memory bus of a debug controller. The shift interface hands it one complete command at a time: an 8-bit opcode together with the 16-bit address and 16-bit data words that follow it. The block decodes the opcode and turns memory commands into single read or write requests on the bus. Each request waits on a request/grant handshake owned by a separate arbiter. Read results, or an error indication, go back to the host as a 16-bit response.

The block holds an 8-bit debug status register. It answers at a fixed address, but only while the debug map is visible. Bit 7 is the firmware-enable bit, which software sets by writing it. Bit 6 reflects whether background mode is active. A background command raises a one-cycle request toward the CPU, and only when the enable bit is set. Memory commands run whether or not background mode is active.

Top module: `dbg_cmd_unit`

## Requirements
- R1: After reset `cmd_ready` is 1, `bus_req`, `rsp_valid` and `bg_req` are 0, and the status register reads 0x00.
- R2: A byte read returns its byte in bits [7:0] when the address is odd, and in bits [15:8] when it is even. The other byte of the response is zero.
- R3: A word read at an even address issues one bus read at that address and returns the full 16-bit bus word.
- R4: A word read at an odd address makes no bus request. In the cycle after acceptance it returns `rsp_valid`=1, `rsp_err`=1 and data 0x0000.
- R5: A byte write (opcode 0xC4) issues one bus write with `bus_we`=1 and `cmd_wdata` passed through. `bus_be` is 2'b01 for an odd address and 2'b10 for an even one. Reads use `bus_be`=2'b11 for words, and the same parity lanes for bytes.
- R6: Opcodes 0xE4 (byte read), 0xEC (word read) and 0xC4 (byte write) drive `bus_dbg_map`=1. Opcodes 0xE0 (byte read) and 0xE8 (word read) drive `bus_dbg_map`=0.
- R7: A byte read at STATUS_ADDR (0xFF01) with the debug map visible makes no bus access. The status byte is {enable, bg_active, 6'b0}, placed by R2's lane rule, and the response comes one cycle after acceptance.
- R8: A byte write at STATUS_ADDR with the debug map visible makes no bus access. It loads the enable bit from bit 7 of the byte selected by the address parity, which is `cmd_wdata[7]` for 0xFF01.
- R9: Opcode 0x90 raises `bg_req` for exactly the one cycle after acceptance when the enable bit is set. When the bit is clear, the command leaves `bg_req` at 0.
- R10: Any other opcode makes no bus request and no response, and `cmd_ready` is 1 again in the next cycle.
- R11: While `bus_req` is high without `bus_gnt`, the address, direction and data stay stable, and `cmd_ready` is 0. A read's response follows one cycle after the grant cycle.
- R12: A byte read at STATUS_ADDR with the debug map hidden (0xE0) goes to the bus with `bus_dbg_map`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A full command is presented |
| cmd_ready | output | 1 | The block can accept a command |
| cmd_opcode | input | 8 | Command opcode |
| cmd_addr | input | 16 | Command address word |
| cmd_wdata | input | 16 | Command data word |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_data | output | 16 | Read response data |
| rsp_err | output | 1 | Response reports a misaligned word read |
| bus_req | output | 1 | Bus access request |
| bus_gnt | input | 1 | Grant; the access completes in this cycle |
| bus_we | output | 1 | 1 for a write |
| bus_dbg_map | output | 1 | 1 when debug resources are mapped in |
| bus_addr | output | 16 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_be | output | 2 | Byte lanes: bit 1 high byte, bit 0 low byte |
| bus_rdata | input | 16 | Read data, sampled in the grant cycle |
| bg_active | input | 1 | Background mode is active |
| bg_req | output | 1 | Enter-background request pulse |

## Verification
The bench builds the block with 16-bit words and a status address of 0xFF01. Because that address is odd, status traffic uses the low byte lane, and a word read aimed at it falls into the misaligned-error path. The grant delay is varied between zero and three cycles, which exercises the hold-while-waiting behaviour and the response timing after a late grant. The enable and active bits are walked through their settings to show the status codes and the gating of the background request.

// File: rtl/dbg_cmd_pkg.sv
// Package: opcode values, decoded command kinds and controller states.
// Assumes: 8-bit opcodes; shared by every module of the debug command unit.
package dbg_cmd_pkg;
    localparam logic [7:0] OP_BGND    = 8'h90;
    localparam logic [7:0] OP_RDB_VIS = 8'hE4;
    localparam logic [7:0] OP_RDW_VIS = 8'hEC;
    localparam logic [7:0] OP_RDB_HID = 8'hE0;
    localparam logic [7:0] OP_RDW_HID = 8'hE8;
    localparam logic [7:0] OP_WRB_VIS = 8'hC4;

    typedef enum logic [2:0] {
        K_NONE,
        K_BGND,
        K_RD_BYTE,
        K_RD_WORD,
        K_WR_BYTE
    } cmd_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_BUS
    } fsm_e;
endpackage

// File: rtl/dbg_op_decode.sv
// Module: maps an opcode to a command kind and a debug-map visibility flag.
// Assumes: purely combinational; unknown opcodes decode to K_NONE.
module dbg_op_decode
    import dbg_cmd_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_kind_e  kind,
    output logic       map_vis
);
    // Fixed opcode table lookup.
    always_comb begin
        kind    = K_NONE;
        map_vis = 1'b0;
        case (opcode)
            OP_BGND:    kind = K_BGND;
            OP_RDB_VIS: begin kind = K_RD_BYTE; map_vis = 1'b1; end
            OP_RDW_VIS: begin kind = K_RD_WORD; map_vis = 1'b1; end
            OP_RDB_HID: kind = K_RD_BYTE;
            OP_RDW_HID: kind = K_RD_WORD;
            OP_WRB_VIS: begin kind = K_WR_BYTE; map_vis = 1'b1; end
            default:    kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/dbg_byte_lane.sv
// Module: extracts read data by address parity; byte results occupy one half.
// Assumes: DATA_W is even; the odd address owns the low half.
module dbg_byte_lane #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic              odd,
    input  logic              byte_op,
    output logic [DATA_W-1:0] rd_out
);
    localparam int LANE_W = DATA_W / 2;

    // Pick and zero-pad the addressed half, or pass the whole word.
    always_comb begin
        if (!byte_op)
            rd_out = word_in;
        else if (odd)
            rd_out = {{LANE_W{1'b0}}, word_in[LANE_W-1:0]};
        else
            rd_out = {word_in[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
    end
endmodule

// File: rtl/dbg_status_reg.sv
// Module: debug status byte = {firmware enable, background active, zeros}.
// Assumes: wr_en is a single-cycle strobe; only the top bit of wr_val is kept.
module dbg_status_reg #(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_val,
    input  logic              bg_active,
    output logic [STAT_W-1:0] status,
    output logic              fw_en
);
    // Enable bit: cleared by reset, loaded from the written top bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fw_en <= 1'b0;
        else if (wr_en)
            fw_en <= wr_val[STAT_W-1];
    end

    // Assemble the readable status byte.
    always_comb status = {fw_en, bg_active, {(STAT_W-2){1'b0}}};

    a_r8_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> fw_en == $past(wr_val[STAT_W-1]));
endmodule

// File: rtl/dbg_cmd_unit.sv
// Module: accepts a decoded debug command, runs it locally or on the bus,
// and returns read data or an alignment error.
// Assumes: one command in flight; bus_rdata is valid in the bus_gnt cycle.
module dbg_cmd_unit
    import dbg_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 16,
    parameter logic [15:0] STATUS_ADDR = 16'hFF01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_opcode,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic              bus_dbg_map,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bg_active,
    output logic              bg_req
);
    localparam int LANE_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

    fsm_e              state;
    cmd_kind_e         dec_kind;
    logic              dec_map;
    logic              cmd_fire, stat_hit, odd_word, stat_rd, stat_wr;
    logic              byte_q;
    logic [1:0]        be_cmd;
    logic [LANE_W-1:0] status, wr_byte;
    logic              fw_en;
    logic [DATA_W-1:0] local_rd, bus_rd;

    dbg_op_decode u_dec (
        .opcode (cmd_opcode),
        .kind   (dec_kind),
        .map_vis(dec_map)
    );

    // Command-side qualifiers.
    always_comb begin
        cmd_fire = cmd_valid && cmd_ready;
        stat_hit = dec_map && (cmd_addr == STAT_A);
        odd_word = (dec_kind == K_RD_WORD) && cmd_addr[0];
        stat_rd  = cmd_fire && stat_hit && (dec_kind == K_RD_BYTE);
        stat_wr  = cmd_fire && stat_hit && (dec_kind == K_WR_BYTE);
        wr_byte  = cmd_addr[0] ? cmd_wdata[LANE_W-1:0] : cmd_wdata[DATA_W-1:LANE_W];
        if (dec_kind == K_RD_WORD) be_cmd = 2'b11;
        else                       be_cmd = cmd_addr[0] ? 2'b01 : 2'b10;
    end

    dbg_status_reg #(.STAT_W(LANE_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stat_wr),
        .wr_val   (wr_byte),
        .bg_active(bg_active),
        .status   (status),
        .fw_en    (fw_en)
    );

    dbg_byte_lane #(.DATA_W(DATA_W)) u_lane_local (
        .word_in({2{status}}),
        .odd    (cmd_addr[0]),
        .byte_op(1'b1),
        .rd_out (local_rd)
    );

    dbg_byte_lane #(.DATA_W(DATA_W)) u_lane_bus (
        .word_in(bus_rdata),
        .odd    (bus_addr[0]),
        .byte_op(byte_q),
        .rd_out (bus_rd)
    );

    // Handshake outputs follow the controller state.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        bus_req   = (state == ST_BUS);
    end

    // Controller: dispatch commands, hold bus requests, register responses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            rsp_valid   <= 1'b0;
            rsp_err     <= 1'b0;
            rsp_data    <= '0;
            bg_req      <= 1'b0;
            bus_we      <= 1'b0;
            bus_dbg_map <= 1'b0;
            bus_addr    <= '0;
            bus_wdata   <= '0;
            bus_be      <= 2'b00;
            byte_q      <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            bg_req    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_fire) begin
                        case (dec_kind)
                            K_BGND: bg_req <= fw_en;
                            K_RD_BYTE, K_RD_WORD, K_WR_BYTE: begin
                                if (odd_word) begin
                                    rsp_valid <= 1'b1;
                                    rsp_err   <= 1'b1;
                                    rsp_data  <= '0;
                                end else if (stat_rd) begin
                                    rsp_valid <= 1'b1;
                                    rsp_data  <= local_rd;
                                end else if (!stat_wr) begin
                                    state       <= ST_BUS;
                                    bus_we      <= (dec_kind == K_WR_BYTE);
                                    bus_dbg_map <= dec_map;
                                    bus_addr    <= cmd_addr;
                                    bus_wdata   <= cmd_wdata;
                                    bus_be      <= be_cmd;
                                    byte_q      <= (dec_kind != K_RD_WORD);
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_BUS: begin
                    if (bus_gnt) begin
                        state <= ST_IDLE;
                        if (!bus_we) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= bus_rd;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r4_odd_word_error: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && odd_word |=> rsp_valid && rsp_err && !bus_req && (rsp_data == '0));
    a_r7_status_local: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> rsp_valid && !bus_req);
    a_r9_bg_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bg_req |=> !bg_req);
    a_r10_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire && (dec_kind == K_NONE) |=> !bus_req && !rsp_valid && cmd_ready);
    a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                                && $stable(bus_wdata) && !cmd_ready);
endmodule

// File: tb/dbg_cmd_unit_tb_top.sv
module dbg_cmd_unit_tb_top;
    typedef struct packed {
        logic [15:0] addr;
        logic        we;
        logic        map;
        logic [1:0]  be;
        logic [15:0] wdata;
    } bus_item_t;
    typedef struct packed {
        logic [15:0] data;
        logic        err;
        logic [7:0]  tag;
    } rsp_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [7:0]  cmd_opcode = 8'h00;
    logic [15:0] cmd_addr = '0, cmd_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [15:0] rsp_data;
    logic        bus_req, bus_gnt = 1'b0, bus_we, bus_dbg_map;
    logic [15:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0]  bus_be;
    logic        bg_active = 1'b0, bg_req;

    int tests = 0, fails = 0, gnt_wait = 0, wait_cnt = 0;
    bus_item_t exp_bus[$];
    rsp_item_t exp_rsp[$];

    always #2 clk = ~clk;

    dbg_cmd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_opcode(cmd_opcode), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_dbg_map(bus_dbg_map),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .bg_active(bg_active), .bg_req(bg_req)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        logic [15:0] w;
        w = a & 16'hFFFE;
        return {w[7:0] ^ 8'h3C, w[15:8] ^ 8'hA7};
    endfunction

    function automatic logic [15:0] byte_exp(input logic [15:0] a);
        logic [15:0] w;
        w = mem_word(a);
        return a[0] ? {8'h00, w[7:0]} : {w[15:8], 8'h00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: bus model with grant delay; compares each granted access.
    always @(negedge clk) begin
        bus_gnt = 1'b0;
        if (rst_n && bus_req) begin
            if (wait_cnt >= gnt_wait) begin
                bus_gnt   = 1'b1;
                bus_rdata = mem_word(bus_addr);
                wait_cnt  = 0;
                if (exp_bus.size() == 0) begin
                    check("R10 unexpected bus access", {16'h0, bus_addr}, 32'hFFFF_FFFF);
                end else begin
                    bus_item_t e;
                    e = exp_bus.pop_front();
                    check("R3/R5/R12 bus addr", {16'h0, bus_addr}, {16'h0, e.addr});
                    check("R5 bus_we", {31'h0, bus_we}, {31'h0, e.we});
                    check("R6 bus_dbg_map", {31'h0, bus_dbg_map}, {31'h0, e.map});
                    check("R5 bus_be", {30'h0, bus_be}, {30'h0, e.be});
                    if (e.we) check("R5 bus_wdata", {16'h0, bus_wdata}, {16'h0, e.wdata});
                end
            end else begin
                wait_cnt++;
                check("R11 cmd_ready low while waiting", {31'h0, cmd_ready}, 32'h0);
            end
        end
    end

    // Monitor: pops expected responses and compares data and error flag.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rsp.size() == 0) begin
                check("R10 unexpected response", {15'h0, rsp_err, rsp_data}, 32'hFFFF_FFFF);
            end else begin
                rsp_item_t e;
                e = exp_rsp.pop_front();
                check($sformatf("R%0s rsp_data", e.tag), {16'h0, rsp_data}, {16'h0, e.data});
                check("R4 rsp_err", {31'h0, rsp_err}, {31'h0, e.err});
            end
        end
    end

    task automatic send(input logic [7:0] op, input logic [15:0] a, input logic [15:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_opcode = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_rsp.size() != 0 || exp_bus.size() != 0 || bus_req) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic rsp_item_t ri(input logic [15:0] d, input logic e, input logic [7:0] t);
        rsp_item_t r;
        r.data = d; r.err = e; r.tag = t;
        return r;
    endfunction

    function automatic bus_item_t bi(input logic [15:0] a, input logic w, input logic m,
                                     input logic [1:0] b, input logic [15:0] d);
        bus_item_t x;
        x.addr = a; x.we = w; x.map = m; x.be = b; x.wdata = d;
        return x;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Driver: stimulus sequence with expectations pushed to the queues.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cmd_ready", {31'h0, cmd_ready}, 32'h1);
        check("R1 bus_req", {31'h0, bus_req}, 32'h0);
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R1 bg_req", {31'h0, bg_req}, 32'h0);

        exp_rsp.push_back(ri(16'h0000, 1'b0, "7"));         // R1 R7 status 0x00
        send(8'hE4, 16'hFF01, 16'h0); drain();

        send(8'h90, 16'h0, 16'h0);                          // R9 gated off
        check("R9 bg_req while disabled", {31'h0, bg_req}, 32'h0);

        send(8'hC4, 16'hFF01, 16'h0080);                    // R8 set enable
        exp_rsp.push_back(ri(16'h0080, 1'b0, "8"));
        send(8'hE4, 16'hFF01, 16'h0); drain();

        send(8'h90, 16'h0, 16'h0);                          // R9 pulse
        check("R9 bg_req pulse", {31'h0, bg_req}, 32'h1);
        @(negedge clk);
        check("R9 bg_req single cycle", {31'h0, bg_req}, 32'h0);

        bg_active = 1'b1;                                   // R7 active code
        exp_rsp.push_back(ri(16'h00C0, 1'b0, "7"));
        send(8'hE4, 16'hFF01, 16'h0); drain();

        exp_bus.push_back(bi(16'h1235, 1'b0, 1'b1, 2'b01, 16'h0));   // R2 R6 odd
        exp_rsp.push_back(ri(byte_exp(16'h1235), 1'b0, "2"));
        send(8'hE4, 16'h1235, 16'h0); drain();
        exp_bus.push_back(bi(16'h2000, 1'b0, 1'b0, 2'b10, 16'h0));   // R2 R6 even hidden
        exp_rsp.push_back(ri(byte_exp(16'h2000), 1'b0, "2"));
        send(8'hE0, 16'h2000, 16'h0); drain();

        gnt_wait = 3;                                       // R3 R11 late grant
        exp_bus.push_back(bi(16'h4000, 1'b0, 1'b1, 2'b11, 16'h0));
        exp_rsp.push_back(ri(mem_word(16'h4000), 1'b0, "3"));
        send(8'hEC, 16'h4000, 16'h0); drain();
        exp_bus.push_back(bi(16'h4002, 1'b0, 1'b0, 2'b11, 16'h0));
        exp_rsp.push_back(ri(mem_word(16'h4002), 1'b0, "3"));
        send(8'hE8, 16'h4002, 16'h0); drain();
        gnt_wait = 0;

        exp_rsp.push_back(ri(16'h0000, 1'b1, "4"));         // R4 misaligned
        send(8'hEC, 16'h4001, 16'h0);
        check("R4 no bus request", {31'h0, bus_req}, 32'h0);
        drain();
        exp_rsp.push_back(ri(16'h0000, 1'b1, "4"));
        send(8'hE8, 16'hFF01, 16'h0); drain();

        exp_bus.push_back(bi(16'h3001, 1'b1, 1'b1, 2'b01, 16'h00AB)); // R5 odd
        send(8'hC4, 16'h3001, 16'h00AB); drain();
        gnt_wait = 2;
        exp_bus.push_back(bi(16'h3000, 1'b1, 1'b1, 2'b10, 16'hCD00)); // R5 even
        send(8'hC4, 16'h3000, 16'hCD00); drain();
        gnt_wait = 0;

        exp_bus.push_back(bi(16'hFF01, 1'b0, 1'b0, 2'b01, 16'h0));   // R12 hidden
        exp_rsp.push_back(ri(byte_exp(16'hFF01), 1'b0, "12"));
        send(8'hE0, 16'hFF01, 16'h0); drain();

        send(8'h55, 16'h1234, 16'h5678);                    // R10 unknown
        check("R10 no bus request", {31'h0, bus_req}, 32'h0);
        check("R10 no response", {31'h0, rsp_valid}, 32'h0);
        check("R10 ready again", {31'h0, cmd_ready}, 32'h1);

        send(8'hC4, 16'hFF01, 16'h0000);                    // R8 clear enable
        bg_active = 1'b0;
        exp_rsp.push_back(ri(16'h0000, 1'b0, "8"));
        send(8'hE4, 16'hFF01, 16'h0); drain();
        send(8'h90, 16'h0, 16'h0);
        check("R9 bg_req after clear", {31'h0, bg_req}, 32'h0);

        repeat (3) @(negedge clk);
        check("R10 queues empty", exp_rsp.size() + exp_bus.size(), 32'h0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule